// File: doc/BRIEF.md
# Speed-Mode PHY Configuration Sequencer

This block reprograms the pad and timing registers of a storage-card PHY each time the host controller changes bus speed mode, bus clock or bus width. It watches a clock code, a bus-width code and an encoded timing mode. When any of these differs from the values it last applied, it runs a fixed series of register updates. The values it writes depend on the mode, on whether the attached card is an SDIO device, on a board strap that requests the slow (bypass) path, and on whether the bus clock is above 52 MHz. Every run ends by starting the PHY init sequencer and waiting until that sequencer reports completion.

Each register update leaves the block as one beat on a valid/ready stream. A beat carries a register selector, a mask of bits to set and a mask of bits to clear, so the downstream register file applies the change as a read-modify-write. While `wr_valid` is high and `wr_ready` is low, the beat is held unchanged. A beat is taken on a rising edge where both signals are high. The block also owns the card clock enable. It drops that enable around the function-register beat so that the PHY mode lanes are never switched under a running clock.

Top module: `phy_mode_seq`

## Requirements
- R1: A run starts only when the sequencer is idle, `clk_code` is nonzero, and `clk_code`, `bus_width` or `speed_mode` differs from the last applied triple. A zero `clk_code` clears the stored clock so that the next nonzero code starts a run. A zero `clk_code` itself causes no beat.
- R2: Beats leave in the order pad-receiver (sel 0), pull (sel 1), timing (sel 2), then, on the full path, impedance (sel 3), function (sel 4) and one final beat. The pad-receiver beat sets bits 28, 26, 25, 24 and 15:12 and clears nothing. The pull beat sets bits 1:0 (command and data pull-up) and clears bits 5:4 (their pull-downs).
- R3: The slow flag is timing-register bit 29. It is forced off when `clk_above_52m` is high. Otherwise, in legacy (mode 0) it follows `slow_strap`. In MMC high speed, SD high speed, SDR12 and SDR25 (modes 1 to 4) it is the OR of `sdio_card` and `slow_strap`. In every other mode it is cleared. Outside legacy, the same beat also sets bit 28 when `sdio_card` is high and clears it when `sdio_card` is low. In legacy, bit 28 is left alone.
- R4: In legacy mode, or when the slow flag is set, the run goes from the timing beat straight to PHY init, after 3 beats in total. All other runs issue 6 beats.
- R5: The impedance beat writes ZNR to bits 12:8 and ZPR to bits 4:0, both 0xF by default, and clears any other bit of those two fields.
- R6: `card_clk_en` goes low one cycle before the function beat is presented. It stays low until that beat is accepted, and then returns high.
- R7: The function beat, by mode. HS400 (mode 7) sets data DDR bits 15:8 and command DDR bit 16 and clears async bit 4. DDR50 and DDR52 (modes 5 and 6) set bits 16:8 and bit 4. Every other mode sets bit 4 and clears bits 16:8.
- R8: The final beat in HS400 is the logic-timing register (sel 5), written in full with 0x00AA8977. In every other mode it is the strobe register (sel 6), clearing its enable bit 0.
- R9: After the last beat of a run, `init_req` pulses for exactly one cycle. `busy` stays high from the cycle after the trigger until `init_done` is seen.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_sel`, `wr_set` and `wr_clr` hold their values.
- R11: After reset, `busy`, `wr_valid` and `init_req` are low and `card_clk_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_code | input | CLK_W | Bus clock setting code; 0 means the bus clock is stopped |
| bus_width | input | BW_W | Bus width code |
| speed_mode | input | 4 | Timing mode: 0 legacy, 1 MMC HS, 2 SD HS, 3 SDR12, 4 SDR25, 5 DDR50, 6 DDR52, 7 HS400, 8 HS200, 9 SDR104 |
| sdio_card | input | 1 | Attached card is an SDIO device |
| slow_strap | input | 1 | Board requests the slow bypass path |
| clk_above_52m | input | 1 | Bus clock is above 52 MHz |
| wr_valid | output | 1 | Register beat is valid |
| wr_ready | input | 1 | Downstream register file accepts the beat |
| wr_sel | output | 3 | Register selector |
| wr_set | output | 32 | Bits to set |
| wr_clr | output | 32 | Bits to clear |
| card_clk_en | output | 1 | Card clock enable |
| init_req | output | 1 | One-cycle start pulse to the PHY init sequencer |
| init_done | input | 1 | PHY init has finished |
| busy | output | 1 | A run is in progress |

## Verification
The assertions check the behaviours that can be observed on every cycle. These are beat stability under back-pressure, the gated clock during any function beat, the slow flag never being set above 52 MHz, the absence of an impedance beat in legacy mode, and the single-cycle init pulse falling inside a busy window. The bench scenarios cover what the assertions cannot see: the whole beat order and its count for each mode, the exact mask values, the retrigger rules, which depend on the stored record (no run on identical inputs, a run after a zero clock, a run on a width change alone), and `busy` holding through a slow init.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;

  typedef enum logic [3:0] {
    M_LEGACY = 4'd0,
    M_MMC_HS = 4'd1,
    M_SD_HS  = 4'd2,
    M_SDR12  = 4'd3,
    M_SDR25  = 4'd4,
    M_DDR50  = 4'd5,
    M_DDR52  = 4'd6,
    M_HS400  = 4'd7,
    M_HS200  = 4'd8,
    M_SDR104 = 4'd9
  } mode_e;

  typedef enum logic [2:0] {
    SEL_PADRX  = 3'd0,
    SEL_PULL   = 3'd1,
    SEL_TIMING = 3'd2,
    SEL_IMPED  = 3'd3,
    SEL_FUNC   = 3'd4,
    SEL_LOGIC  = 3'd5,
    SEL_STROBE = 3'd6
  } sel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PADRX, S_PULL, S_TIMING, S_IMPED,
    S_GATE, S_FUNC, S_FINAL, S_INIT, S_WAIT
  } state_e;

  localparam int unsigned TIM_SLOW_BIT = 29;
  localparam int unsigned TIM_SDIO_BIT = 28;
  localparam logic [31:0] PADRX_SET = 32'h1700_F000;
  localparam logic [31:0] PULL_SET  = 32'h0000_0003;
  localparam logic [31:0] PULL_CLR  = 32'h0000_0030;

endpackage

// File: rtl/phycfg_decode.sv
module phycfg_decode
  import phycfg_pkg::*;
#(
  parameter logic [4:0]  ZNR       = 5'hF,
  parameter logic [4:0]  ZPR       = 5'hF,
  parameter int          DQ_LANES  = 8,
  parameter logic [31:0] LOGIC_VAL = 32'h00AA_8977
) (
  input  logic [3:0]  mode,
  input  logic        sdio,
  input  logic        strap,
  input  logic        fast,
  output logic        legacy,
  output logic        slow,
  output logic [31:0] tim_set,
  output logic [31:0] tim_clr,
  output logic [31:0] imp_set,
  output logic [31:0] imp_clr,
  output logic [31:0] func_set,
  output logic [31:0] func_clr,
  output logic [2:0]  final_sel,
  output logic [31:0] final_set,
  output logic [31:0] final_clr
);
  localparam int          DQ_LSB    = 8;
  localparam int          CMD_BIT   = DQ_LSB + DQ_LANES;
  localparam logic [31:0] DQ_MASK   = ((32'h1 << DQ_LANES) - 32'h1) << DQ_LSB;
  localparam logic [31:0] CMD_MASK  = 32'h1 << CMD_BIT;
  localparam logic [31:0] ASYNC     = 32'h0000_0010;
  localparam logic [31:0] IMP_FIELD = 32'h0000_1F1F;

  logic low_speed, ddr_mode, hs400;

  always_comb begin
    legacy    = (mode == M_LEGACY);
    low_speed = (mode == M_MMC_HS) || (mode == M_SD_HS) ||
                (mode == M_SDR12)  || (mode == M_SDR25);
    ddr_mode  = (mode == M_DDR50)  || (mode == M_DDR52);
    hs400     = (mode == M_HS400);

    if (fast)           slow = 1'b0;
    else if (legacy)    slow = strap;
    else if (low_speed) slow = sdio | strap;
    else                slow = 1'b0;

    tim_set = 32'(slow)  << TIM_SLOW_BIT;
    tim_clr = 32'(!slow) << TIM_SLOW_BIT;
    if (!legacy) begin
      tim_set |= 32'(sdio)  << TIM_SDIO_BIT;
      tim_clr |= 32'(!sdio) << TIM_SDIO_BIT;
    end

    imp_set = {19'd0, ZNR, 3'd0, ZPR};
    imp_clr = IMP_FIELD & ~imp_set;

    if (hs400) begin
      func_set = DQ_MASK | CMD_MASK;
      func_clr = ASYNC;
    end else if (ddr_mode) begin
      func_set = DQ_MASK | CMD_MASK | ASYNC;
      func_clr = 32'd0;
    end else begin
      func_set = ASYNC;
      func_clr = DQ_MASK | CMD_MASK;
    end

    if (hs400) begin
      final_sel = SEL_LOGIC;
      final_set = LOGIC_VAL;
      final_clr = ~LOGIC_VAL;
    end else begin
      final_sel = SEL_STROBE;
      final_set = 32'd0;
      final_clr = 32'h1;
    end
  end

endmodule

// File: rtl/phycfg_tracker.sv
module phycfg_tracker #(
  parameter int CLK_W = 8,
  parameter int BW_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic [CLK_W-1:0] clk_code,
  input  logic [BW_W-1:0]  bus_width,
  input  logic [3:0]       mode,
  output logic             start
);
  logic [CLK_W-1:0] last_clk;
  logic [BW_W-1:0]  last_bw;
  logic [3:0]       last_mode;
  logic             clk_on, differs;

  always_comb begin
    clk_on  = (clk_code != '0);
    differs = (clk_code != last_clk) || (bus_width != last_bw) ||
              (mode != last_mode);
    start   = idle && clk_on && differs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_clk  <= '0;
      last_bw   <= '0;
      last_mode <= '0;
    end else if (idle && !clk_on) begin
      last_clk <= '0;
    end else if (start) begin
      last_clk  <= clk_code;
      last_bw   <= bus_width;
      last_mode <= mode;
    end
  end

endmodule

// File: rtl/phy_mode_seq.sv
module phy_mode_seq
  import phycfg_pkg::*;
#(
  parameter int          CLK_W     = 8,
  parameter int          BW_W      = 2,
  parameter logic [4:0]  ZNR       = 5'hF,
  parameter logic [4:0]  ZPR       = 5'hF,
  parameter int          DQ_LANES  = 8,
  parameter logic [31:0] LOGIC_VAL = 32'h00AA_8977
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CLK_W-1:0] clk_code,
  input  logic [BW_W-1:0]  bus_width,
  input  logic [3:0]       speed_mode,
  input  logic             sdio_card,
  input  logic             slow_strap,
  input  logic             clk_above_52m,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [2:0]       wr_sel,
  output logic [31:0]      wr_set,
  output logic [31:0]      wr_clr,
  output logic             card_clk_en,
  output logic             init_req,
  input  logic             init_done,
  output logic             busy
);
  state_e      state, state_n;
  logic        start;
  logic [3:0]  mode_q;
  logic        sdio_q, strap_q, fast_q;
  logic        legacy, slow;
  logic [31:0] tim_set, tim_clr, imp_set, imp_clr;
  logic [31:0] func_set, func_clr, final_set, final_clr;
  logic [2:0]  final_sel;
  logic        clk_en_q;

  phycfg_tracker #(.CLK_W(CLK_W), .BW_W(BW_W)) u_track (
    .clk(clk), .rst_n(rst_n), .idle(state == S_IDLE),
    .clk_code(clk_code), .bus_width(bus_width), .mode(speed_mode),
    .start(start)
  );

  phycfg_decode #(.ZNR(ZNR), .ZPR(ZPR), .DQ_LANES(DQ_LANES),
                  .LOGIC_VAL(LOGIC_VAL)) u_dec (
    .mode(mode_q), .sdio(sdio_q), .strap(strap_q), .fast(fast_q),
    .legacy(legacy), .slow(slow),
    .tim_set(tim_set), .tim_clr(tim_clr),
    .imp_set(imp_set), .imp_clr(imp_clr),
    .func_set(func_set), .func_clr(func_clr),
    .final_sel(final_sel), .final_set(final_set), .final_clr(final_clr)
  );

  // beat contents and next state
  always_comb begin
    wr_valid = 1'b0;
    wr_sel   = SEL_PADRX;
    wr_set   = '0;
    wr_clr   = '0;
    init_req = 1'b0;
    state_n  = state;
    case (state)
      S_IDLE:   if (start) state_n = S_PADRX;
      S_PADRX: begin
        wr_valid = 1'b1; wr_sel = SEL_PADRX; wr_set = PADRX_SET;
        if (wr_ready) state_n = S_PULL;
      end
      S_PULL: begin
        wr_valid = 1'b1; wr_sel = SEL_PULL; wr_set = PULL_SET; wr_clr = PULL_CLR;
        if (wr_ready) state_n = S_TIMING;
      end
      S_TIMING: begin
        wr_valid = 1'b1; wr_sel = SEL_TIMING; wr_set = tim_set; wr_clr = tim_clr;
        if (wr_ready) state_n = (legacy || slow) ? S_INIT : S_IMPED;
      end
      S_IMPED: begin
        wr_valid = 1'b1; wr_sel = SEL_IMPED; wr_set = imp_set; wr_clr = imp_clr;
        if (wr_ready) state_n = S_GATE;
      end
      S_GATE:   state_n = S_FUNC;
      S_FUNC: begin
        wr_valid = 1'b1; wr_sel = SEL_FUNC; wr_set = func_set; wr_clr = func_clr;
        if (wr_ready) state_n = S_FINAL;
      end
      S_FINAL: begin
        wr_valid = 1'b1; wr_sel = final_sel; wr_set = final_set; wr_clr = final_clr;
        if (wr_ready) state_n = S_INIT;
      end
      S_INIT: begin
        init_req = 1'b1;
        state_n  = S_WAIT;
      end
      S_WAIT:   if (init_done) state_n = S_IDLE;
      default:  state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      clk_en_q <= 1'b1;
      mode_q   <= '0;
      sdio_q   <= 1'b0;
      strap_q  <= 1'b0;
      fast_q   <= 1'b0;
    end else begin
      state    <= state_n;
      clk_en_q <= !((state_n == S_GATE) || (state_n == S_FUNC));
      if (start) begin
        mode_q  <= speed_mode;
        sdio_q  <= sdio_card;
        strap_q <= slow_strap;
        fast_q  <= clk_above_52m;
      end
    end
  end

  assign busy        = (state != S_IDLE);
  assign card_clk_en = clk_en_q;

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_sel) && $stable(wr_set) && $stable(wr_clr)) // R10
    else $error("beat changed under back-pressure");
  AST_FUNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && (wr_sel == SEL_FUNC) |-> !card_clk_en) // R6
    else $error("function beat with clock running");
  AST_SLOW_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && (wr_sel == SEL_TIMING) && fast_q |-> !wr_set[TIM_SLOW_BIT]) // R3
    else $error("slow flag set above 52 MHz");
  AST_LEGACY_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && (wr_sel == SEL_IMPED) |-> (mode_q != M_LEGACY)) // R4
    else $error("legacy run reached impedance beat");
  AST_INIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> !init_req) // R9
    else $error("init request longer than one cycle");
  AST_INIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |-> busy && !wr_valid) // R9
    else $error("init request outside a run");

endmodule

// File: tb/test_phy_mode_seq.sv
module test_phy_mode_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_code = 8'd0;
  logic [1:0]  bus_width = 2'd0;
  logic [3:0]  speed_mode = 4'd0;
  logic        sdio_card = 1'b0, slow_strap = 1'b0, clk_above_52m = 1'b0;
  logic        wr_valid, wr_ready = 1'b1;
  logic [2:0]  wr_sel;
  logic [31:0] wr_set, wr_clr;
  logic        card_clk_en, init_req, busy;
  logic        init_done = 1'b0;

  always #10 clk = ~clk;

  phy_mode_seq i_phy_mode_seq (
    .clk(clk), .rst_n(rst_n), .clk_code(clk_code), .bus_width(bus_width),
    .speed_mode(speed_mode), .sdio_card(sdio_card), .slow_strap(slow_strap),
    .clk_above_52m(clk_above_52m), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_set(wr_set), .wr_clr(wr_clr),
    .card_clk_en(card_clk_en), .init_req(init_req), .init_done(init_done),
    .busy(busy)
  );

  int checks = 0, fails = 0;
  int cycles = 0;
  bit stall = 0;
  int init_lat = 3;
  int clr_gen = 0;

  // monitor state
  logic [31:0] set_log [8];
  logic [31:0] clr_log [8];
  logic [17:0] ord;
  int nwr, gate_bad, init_pulses, seen_gen;
  int init_cnt = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (seen_gen != clr_gen) begin
      seen_gen = clr_gen;
      nwr = 0; ord = '0; gate_bad = 0; init_pulses = 0;
      for (int i = 0; i < 8; i++) begin set_log[i] = 'x; clr_log[i] = 'x; end
    end
    if (rst_n && wr_valid && wr_ready) begin
      set_log[wr_sel] = wr_set;
      clr_log[wr_sel] = wr_clr;
      ord = {ord[14:0], wr_sel};
      nwr++;
      if (wr_sel == 3'd4 && card_clk_en) gate_bad++;
    end
    if (rst_n && init_req) init_pulses++;
  end

  // init responder
  always @(negedge clk) begin
    if (init_cnt != 0) begin
      init_cnt--;
      init_done = (init_cnt == 0);
    end else init_done = 1'b0;
    if (rst_n && init_req) init_cnt = init_lat;
  end

  // ready driver
  always @(posedge clk) begin
    cycles++;
    #2;
    wr_ready = stall ? (cycles % 3 == 0) : 1'b1;
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic apply(input logic [3:0] m, input logic s, input logic st,
                       input logic f, input logic [1:0] bw, input logic [7:0] code);
    @(posedge clk); #3;
    speed_mode = m; sdio_card = s; slow_strap = st; clk_above_52m = f;
    bus_width = bw; clk_code = code;
    clr_gen++;
  endtask

  task automatic wait_run(output bit started);
    started = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) begin started = 1; break; end
    end
    if (started) begin
      for (int i = 0; i < 500; i++) begin
        @(negedge clk);
        if (!busy) break;
      end
      if (busy) begin
        fails++;
        $display("FAIL R9 run did not finish actual=busy expected=idle");
      end
    end
  endtask

  typedef struct packed {
    logic [3:0] mode; logic sdio; logic strap; logic fast; logic slow; logic [2:0] n;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{4'd0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd3},
    '{4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{4'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3},
    '{4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 3'd6},
    '{4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 3'd6},
    '{4'd7, 1'b0, 1'b1, 1'b1, 1'b0, 3'd6},
    '{4'd3, 1'b0, 1'b1, 1'b1, 1'b0, 3'd6},
    '{4'd6, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6},
    '{4'd8, 1'b1, 1'b1, 1'b1, 1'b0, 3'd6},
    '{4'd2, 1'b0, 1'b1, 1'b0, 1'b1, 3'd3}
  };

  task automatic check_run(input vec_t v);
    logic [31:0] es, ec, fs, fc;
    logic nonleg;
    nonleg = (v.mode != 4'd0);
    chk("R4 beat count", 32'(nwr), 32'(v.n));
    chk("R9 init pulses", 32'(init_pulses), 32'd1);
    chk("R2 pad beat", set_log[0], 32'h1700_F000);
    chk("R2 pull beat", {set_log[1][15:0], clr_log[1][15:0]}, {16'h0003, 16'h0030});
    es = (32'(v.slow) << 29) | (32'(nonleg & v.sdio) << 28);
    ec = (32'(!v.slow) << 29) | (32'(nonleg & !v.sdio) << 28);
    chk("R3 timing set", set_log[2], es);
    chk("R3 timing clr", clr_log[2], ec);
    if (v.n == 3'd3) begin
      chk("R2 order short", 32'(ord), 32'h0000_000A);
    end else begin
      if (v.mode == 4'd7) begin fs = 32'h0001_FF00; fc = 32'h10; end
      else if (v.mode == 4'd5 || v.mode == 4'd6) begin fs = 32'h0001_FF10; fc = 32'h0; end
      else begin fs = 32'h10; fc = 32'h0001_FF00; end
      chk("R2 order full", 32'(ord), 32'h14E0 + ((v.mode == 4'd7) ? 32'd5 : 32'd6));
      chk("R5 impedance", {set_log[3][15:0], clr_log[3][15:0]}, {16'h0F0F, 16'h1010});
      chk("R7 func set", set_log[4], fs);
      chk("R7 func clr", clr_log[4], fc);
      chk("R6 clock gated", 32'(gate_bad), 32'd0);
      if (v.mode == 4'd7) chk("R8 logic timing", set_log[5], 32'h00AA_8977);
      else                chk("R8 strobe clear", {set_log[6][0], clr_log[6][0]}, {1'b0, 1'b1});
    end
  endtask

  initial begin
    bit st;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 wr_valid", 32'(wr_valid), 32'd0);
    chk("R11 init_req", 32'(init_req), 32'd0);
    chk("R11 card_clk_en", 32'(card_clk_en), 32'd1);

    for (int i = 0; i < 10; i++) begin
      apply(VEC[i].mode, VEC[i].sdio, VEC[i].strap, VEC[i].fast, 2'd1, 8'(i + 1));
      wait_run(st);
      chk("R1 run started", 32'(st), 32'd1);
      check_run(VEC[i]);
      chk("R6 clock restored", 32'(card_clk_en), 32'd1);
    end

    // R1: identical inputs do not retrigger
    apply(4'd2, 1'b0, 1'b1, 1'b0, 2'd1, 8'd10);
    wait_run(st);
    chk("R1 no change no run", 32'(st), 32'd0);
    chk("R1 no change no beat", 32'(nwr), 32'd0);

    // R1: zero clock writes nothing, then same code retriggers
    apply(4'd2, 1'b0, 1'b1, 1'b0, 2'd1, 8'd0);
    wait_run(st);
    chk("R1 zero clock no run", 32'(st), 32'd0);
    chk("R1 zero clock no beat", 32'(nwr), 32'd0);
    apply(4'd2, 1'b0, 1'b1, 1'b0, 2'd1, 8'd10);
    wait_run(st);
    chk("R1 rerun after zero clock", 32'(st), 32'd1);

    // R1: width change alone
    apply(4'd2, 1'b0, 1'b1, 1'b0, 2'd2, 8'd10);
    wait_run(st);
    chk("R1 width change run", 32'(st), 32'd1);

    // R10: back-pressure on a full HS400 run
    stall = 1;
    apply(4'd7, 1'b0, 1'b0, 1'b1, 2'd2, 8'd40);
    wait_run(st);
    chk("R10 stalled run", 32'(st), 32'd1);
    check_run(VEC[5]);
    stall = 0;

    // R9: busy holds while init is slow
    init_lat = 10;
    apply(4'd0, 1'b0, 1'b0, 1'b0, 2'd2, 8'd50);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (init_pulses != 0) break;
    end
    repeat (5) @(negedge clk);
    chk("R9 busy during init", 32'(busy), 32'd1);
    wait_run(st);
    chk("R9 idle after done", 32'(busy), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule